// File: doc/BRIEF.md
# Message Digest Register Front-End

This block is the register-mapped control and status shell of a message-digest accelerator for MD5, SHA-1, SHA-224 and SHA-256. Software writes the message length in bits and then a control word that picks the algorithm and a byte-lane order, and this write opens a new job. It then pushes the message as 32-bit words through a separate write-only data port, either from a processor or from a DMA engine. Each word is reordered by lanes and handed to the digest core. When the core finishes, the digest words are loaded into a result queue. Each read of the queue pops one word.

A status register records completion and two sticky misuse errors: a read from an empty queue, and a data word that arrives when no job is taking data. Software clears status bits by writing ones. A level interrupt is the OR of the status bits that the enable register lets through. The compression logic is replaced by a stub. The stub folds each accepted word into a 32-bit accumulator and produces its digest a fixed number of cycles after the last expected word. A software-controlled reset register holds everything else cleared while it is set.

Top module: `hash_regfront`

## Requirements
- R1: After reset, the registers at 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 read zero, and `irq` is low. The read-only register at 0x50 returns the REVISION parameter.
- R2: The length registers (high word at 0x04, low word at 0x08) read back as written. The control register at 0x0C reads back bits [1:0] and [9:8] as written, with all other bits zero.
- R3: Control bits [9:8] reorder the bytes of each data word. The output is listed from the most significant lane down, with b3 as the input's top byte. Mode 0 gives b3 b2 b1 b0, mode 1 gives b0 b1 b2 b3, mode 2 gives b2 b3 b1 b0, and mode 3 gives b1 b0 b3 b2.
- R4: A data word written in the cycle right after a control write is dropped and sets status bit 3. A word written two cycles after the control write is accepted.
- R5: A data word is dropped and sets status bit 3 in any of these cases: no control write has occurred since reset, the previous job has taken all its words, or the job has completed.
- R6: A job expects ceil(L/32) words, where L is the 64-bit bit length. DELAY cycles after the clock edge that accepts the last word, the queue is loaded and status bits 0 and 1 are set in the same edge. For a zero length, the count starts at the edge of the control write.
- R7: The stub's accumulator starts at zero when a job opens. Each accepted, reordered word w updates it to rotl1(acc) xor w. Digest word k is acc xor (0x01010101*(k+1)), for k from 0 to n-1. n is 4, 5, 7 or 8 for algorithm codes 0 (MD5), 1 (SHA-1), 2 (SHA-224) and 3 (SHA-256). Reads of 0x1C return the words byte-reversed, starting with word n-1 and ending with word 0.
- R8: A read of 0x1C while the queue is empty returns zero and sets status bit 2. It leaves the queue's state unchanged, so later loads and reads are unaffected.
- R9: Status bits [3:0] at 0x10 stay set until software writes a 1 to the matching bit of 0x18. Writes to 0x18 change nothing else.
- R10: `irq` equals the OR of status[3:0] ANDed with enable[3:0] (register 0x14). Bit 8 of 0x10 reads the same value.
- R11: Writing 1 to bit 0 of 0x00 holds every other register, the queue and any job cleared. Other register writes and data words are ignored while it is held, and 0x00 reads 1. Writing 0 releases the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of 0x1C pops the queue |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of the read |
| data_wr | input | 1 | Data-port write strobe |
| data_wdata | input | 32 | Message word |
| irq | output | 1 | Level interrupt |

## Verification
Register reads are combinational, so the bench compares read data in the same cycle it raises the strobe. Status effects of a write or read become visible one edge later. The queue load and status bits 0 and 1 are due exactly DELAY edges after the last accepted word. The bench polls status every cycle after the last word and requires the first set reading on poll DELAY+1. A behavioural model advanced on each rising edge predicts every read and the `irq` level. The bench compares `irq` with the model at every falling edge, so an early or late interrupt by one cycle shows up as a mismatch.

// File: rtl/hrf_pkg.sv
// Shared widths, algorithm codes and small helpers for the hash register front-end.
// Assumes 32-bit words and a 64-bit bit-length.
package hrf_pkg;
    localparam int WORD_W  = 32;
    localparam int LEN_W   = 64;
    localparam int WCNT_W  = LEN_W - 5;
    localparam int MAX_DIG = 8;

    typedef enum logic [1:0] {
        ALG_MD5    = 2'd0,
        ALG_SHA1   = 2'd1,
        ALG_SHA224 = 2'd2,
        ALG_SHA256 = 2'd3
    } alg_e;

    typedef logic [MAX_DIG-1:0][WORD_W-1:0] digest_t;

    // Number of digest words produced for an algorithm
    function automatic logic [3:0] dig_words(alg_e a);
        case (a)
            ALG_MD5:    return 4'd4;
            ALG_SHA1:   return 4'd5;
            ALG_SHA224: return 4'd7;
            default:    return 4'd8;
        endcase
    endfunction

    // Full byte reversal of a word
    function automatic logic [WORD_W-1:0] byte_rev(logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
endpackage

// File: rtl/hrf_lane_swap.sv
// Byte-lane permutation of one data-port word, selected by a 2-bit mode.
// Purely combinational; assumes 32-bit words.
module hrf_lane_swap (
    input  logic [1:0]  mode,
    input  logic [31:0] din,
    output logic [31:0] dout
);
    // Pick the lane order for the selected mode
    always_comb begin
        case (mode)
            2'd0:    dout = din;
            2'd1:    dout = {din[7:0],   din[15:8],  din[23:16], din[31:24]};
            2'd2:    dout = {din[23:16], din[31:24], din[15:8],  din[7:0]};
            default: dout = {din[15:8],  din[7:0],   din[31:24], din[23:16]};
        endcase
    end
endmodule

// File: rtl/hrf_stub_core.sv
// Stand-in for the compression cores: folds accepted words into an accumulator,
// and pulses done DELAY edges after the last expected word has been taken.
// Assumes DELAY >= 2 and that the target word count is stable during a job.
module hrf_stub_core
    import hrf_pkg::*;
#(
    parameter int DELAY = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  alg_e              algo,
    input  logic [WCNT_W-1:0] target,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word,
    output logic              collecting,
    output logic              done,
    output digest_t           digest,
    output logic [3:0]        n_words
);
    localparam int CNT_W = $clog2(DELAY) + 1;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAIT} st_e;

    st_e               st_q;
    logic [WCNT_W-1:0] words_q;
    logic [WORD_W-1:0] acc_q;
    alg_e              algo_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              reach;

    assign reach      = (st_q == ST_RUN) && (words_q >= target);
    assign collecting = (st_q == ST_RUN) && !reach;
    assign done       = (st_q == ST_WAIT) && (cnt_q == '0);
    assign n_words    = dig_words(algo_q);

    // Job sequencing, word folding and completion countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            words_q <= '0;
            acc_q   <= '0;
            algo_q  <= ALG_MD5;
            cnt_q   <= '0;
        end else if (start) begin
            st_q    <= ST_RUN;
            words_q <= '0;
            acc_q   <= '0;
            algo_q  <= algo;
        end else begin
            case (st_q)
                ST_RUN: begin
                    if (word_vld) begin
                        words_q <= words_q + 1'b1;
                        acc_q   <= {acc_q[WORD_W-2:0], acc_q[WORD_W-1]} ^ word;
                    end
                    if (reach) begin
                        st_q  <= ST_WAIT;
                        cnt_q <= CNT_W'(DELAY - 2);
                    end
                end
                ST_WAIT: begin
                    if (cnt_q == '0) st_q <= ST_IDLE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Digest words derived from the accumulator
    for (genvar k = 0; k < MAX_DIG; k++) begin : g_dig
        assign digest[k] = acc_q ^ (32'h0101_0101 * 32'(k + 1));
    end

    // R6: completion is a single-cycle event
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/hrf_result_fifo.sv
// Result queue: loaded in parallel with a finished digest (last word first,
// byte-reversed) and popped one word per read. Empty pops change nothing.
// Assumes DEPTH >= MAX_DIG.
module hrf_result_fifo
    import hrf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [3:0]        n_words,
    input  digest_t           digest,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic              empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WORD_W-1:0] mem_q    [DEPTH];
    logic [WORD_W-1:0] load_img [DEPTH];
    logic [PTR_W-1:0]  rd_q;
    logic [CNT_W-1:0]  cnt_q;

    // Build the queue image: slot i holds digest word n-1-i, byte-reversed
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            load_img[i] = '0;
            if (i < int'(n_words)) load_img[i] = byte_rev(digest[int'(n_words) - 1 - i]);
        end
    end

    // Load replaces contents; pop advances only when data is present
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            mem_q <= load_img;
            rd_q  <= '0;
            cnt_q <= CNT_W'(n_words);
        end else if (pop && cnt_q != '0) begin
            rd_q  <= rd_q + 1'b1;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign empty = (cnt_q == '0);
    assign head  = empty ? '0 : mem_q[rd_q];

    // R8: a pop on an empty queue leaves it empty
    assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !load) |=> empty);
    // R7: a load holds exactly the algorithm's word count
    assert_load_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == CNT_W'($past(n_words))));
endmodule

// File: rtl/hash_regfront.sv
// Register front-end of the message-digest engine: length/control/interrupt
// registers, soft reset, data-port admission with a two-cycle start guard,
// lane reordering, stub core and result queue. Reads are combinational.
// Assumes one register access per cycle and QDEPTH >= 8.
module hash_regfront
    import hrf_pkg::*;
#(
    parameter int          DELAY    = 6,
    parameter int          QDEPTH   = 8,
    parameter int          ADDR_W   = 8,
    parameter logic [31:0] REVISION = 32'h0001_0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              data_wr,
    input  logic [31:0]       data_wdata,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_RST = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] A_LHI = ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] A_LLO = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(8'h0C);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(8'h10);
    localparam logic [ADDR_W-1:0] A_ENA = ADDR_W'(8'h14);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(8'h18);
    localparam logic [ADDR_W-1:0] A_QUE = ADDR_W'(8'h1C);
    localparam logic [ADDR_W-1:0] A_REV = ADDR_W'(8'h50);

    logic              soft_q, core_rst_n;
    logic [31:0]       len_hi_q, len_lo_q;
    alg_e              alg_q;
    logic [1:0]        ord_q;
    logic [3:0]        en_q, st_q, st_set, st_clr;
    logic              guard_q;
    logic              ctl_wr, accept, bad_data, pop;
    logic [WCNT_W-1:0] target;
    logic [31:0]       swapped, q_head;
    logic              collecting, done, q_empty;
    logic [3:0]        n_words;
    digest_t           digest;

    assign core_rst_n = rst_n && !soft_q;
    assign ctl_wr     = reg_wr && (reg_addr == A_CTL) && core_rst_n;
    assign target     = {len_hi_q, len_lo_q[31:5]} + WCNT_W'(|len_lo_q[4:0]);
    assign accept     = data_wr && core_rst_n && collecting && !guard_q;
    assign bad_data   = data_wr && core_rst_n && !accept;
    assign pop        = reg_rd && (reg_addr == A_QUE) && core_rst_n;
    assign st_set     = {bad_data, pop && q_empty, done, done};
    assign st_clr     = (reg_wr && reg_addr == A_CLR) ? reg_wdata[3:0] : 4'd0;
    assign irq        = |(st_q & en_q);

    // Soft reset bit, cleared only by the hard reset
    always_ff @(posedge clk) begin
        if (!rst_n)                          soft_q <= 1'b0;
        else if (reg_wr && reg_addr == A_RST) soft_q <= reg_wdata[0];
    end

    // Configuration, guard and sticky status registers
    always_ff @(posedge clk) begin
        if (!core_rst_n) begin
            len_hi_q <= '0;
            len_lo_q <= '0;
            alg_q    <= ALG_MD5;
            ord_q    <= '0;
            en_q     <= '0;
            st_q     <= '0;
            guard_q  <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == A_LHI) len_hi_q <= reg_wdata;
            if (reg_wr && reg_addr == A_LLO) len_lo_q <= reg_wdata;
            if (reg_wr && reg_addr == A_ENA) en_q     <= reg_wdata[3:0];
            if (ctl_wr) begin
                alg_q <= alg_e'(reg_wdata[1:0]);
                ord_q <= reg_wdata[9:8];
            end
            guard_q <= ctl_wr;
            st_q    <= (st_q & ~st_clr) | st_set;
        end
    end

    // Register read multiplexer
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                A_RST:   reg_rdata = {31'd0, soft_q};
                A_LHI:   reg_rdata = len_hi_q;
                A_LLO:   reg_rdata = len_lo_q;
                A_CTL:   reg_rdata = {22'd0, ord_q, 6'd0, alg_q};
                A_STS:   reg_rdata = {23'd0, irq, 4'd0, st_q};
                A_ENA:   reg_rdata = {28'd0, en_q};
                A_QUE:   reg_rdata = q_head;
                A_REV:   reg_rdata = REVISION;
                default: reg_rdata = '0;
            endcase
        end
    end

    hrf_lane_swap u_swap (
        .mode (ord_q),
        .din  (data_wdata),
        .dout (swapped)
    );

    hrf_stub_core #(.DELAY(DELAY)) u_core (
        .clk        (clk),
        .rst_n      (core_rst_n),
        .start      (ctl_wr),
        .algo       (alg_e'(reg_wdata[1:0])),
        .target     (target),
        .word_vld   (accept),
        .word       (swapped),
        .collecting (collecting),
        .done       (done),
        .digest     (digest),
        .n_words    (n_words)
    );

    hrf_result_fifo #(.DEPTH(QDEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (core_rst_n),
        .load    (done),
        .n_words (n_words),
        .digest  (digest),
        .pop     (pop),
        .head    (q_head),
        .empty   (q_empty)
    );

    // R4: no word is taken in the cycle right after a control write
    assert_start_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !$past(ctl_wr));
    // R5: a refused word always leaves the write-error flag set
    assert_refused_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && core_rst_n && !collecting) |=> st_q[3]);
    // R9: without a clear write, no status bit drops
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst_n && !(reg_wr && reg_addr == A_CLR)) |=>
        ((st_q & $past(st_q)) == $past(st_q)));
endmodule

// File: tb/hash_regfront_bench.sv
module hash_regfront_bench;
    localparam int          DLY = 6;
    localparam logic [31:0] REV = 32'h0001_0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, data_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, data_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int compared = 0, mismatched = 0;
    longint cyc = 0;
    int wd = 0;

    always #2 clk = ~clk;

    hash_regfront #(.DELAY(DLY), .REVISION(REV)) u_hash_regfront (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .data_wr(data_wr), .data_wdata(data_wdata), .irq(irq));

    // ---------------- reference model ----------------
    bit          m_soft, m_coll, m_wait, m_guard, m_ld, m_ok;
    logic [31:0] m_lhi, m_llo, m_acc;
    logic [1:0]  m_algo, m_ord;
    logic [3:0]  m_en, m_st, m_set, m_clr;
    int          m_jn;
    longint      m_due;
    longint unsigned m_words;
    logic [31:0] m_q[$];

    function automatic logic [31:0] b_rev(logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] p_perm(logic [31:0] w, logic [1:0] m);
        logic [7:0] b3 = w[31:24], b2 = w[23:16], b1 = w[15:8], b0 = w[7:0];
        case (m)
            2'd0: return {b3, b2, b1, b0};
            2'd1: return {b0, b1, b2, b3};
            2'd2: return {b2, b3, b1, b0};
            default: return {b1, b0, b3, b2};
        endcase
    endfunction

    function automatic int alg_n(logic [1:0] a);
        case (a) 2'd0: return 4; 2'd1: return 5; 2'd2: return 7; default: return 8; endcase
    endfunction

    function automatic longint unsigned m_target();
        longint unsigned l = {m_lhi, m_llo};
        return (l / 32) + ((l % 32) != 0 ? 1 : 0);
    endfunction

    task automatic m_clear();
        m_coll = 0; m_wait = 0; m_guard = 0; m_lhi = 0; m_llo = 0; m_acc = 0;
        m_algo = 0; m_ord = 0; m_en = 0; m_st = 0; m_jn = 4; m_due = 0;
        m_words = 0; m_q.delete();
    endtask

    function automatic logic m_irq();
        return |(m_st & m_en);
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        case (a)
            8'h00: return {31'd0, m_soft};
            8'h04: return m_lhi;
            8'h08: return m_llo;
            8'h0C: return {22'd0, m_ord, 6'd0, m_algo};
            8'h10: return {23'd0, m_irq(), 4'd0, m_st};
            8'h14: return {28'd0, m_en};
            8'h1C: return (m_q.size() != 0) ? m_q[0] : 32'd0;
            8'h50: return REV;
            default: return 32'd0;
        endcase
    endfunction

    // Model advances on each rising edge from the inputs held in that cycle
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_clear(); m_soft = 0;
        end else if (m_soft) begin
            m_clear();
            if (reg_wr && reg_addr == 8'h00) m_soft = reg_wdata[0];
        end else begin
            m_set = 0; m_clr = 0;
            m_ld = m_wait && (cyc == m_due);
            m_ok = data_wr && m_coll && !m_guard;
            if (data_wr && !m_ok) m_set[3] = 1;
            if (m_ok) begin
                m_acc = {m_acc[30:0], m_acc[31]} ^ p_perm(data_wdata, m_ord);
                m_words++;
                if (m_words >= m_target()) begin m_coll = 0; m_wait = 1; m_due = cyc + DLY; end
            end
            if (reg_rd && reg_addr == 8'h1C) begin
                if (m_q.size() == 0) m_set[2] = 1;
                else void'(m_q.pop_front());
            end
            if (m_ld) begin
                m_q.delete();
                for (int k = m_jn - 1; k >= 0; k--)
                    m_q.push_back(b_rev(m_acc ^ (32'h0101_0101 * (k + 1))));
                m_set[1:0] = 2'b11;
                m_wait = 0;
            end
            m_guard = 0;
            if (reg_wr) begin
                case (reg_addr)
                    8'h00: m_soft = reg_wdata[0];
                    8'h04: m_lhi = reg_wdata;
                    8'h08: m_llo = reg_wdata;
                    8'h0C: begin
                        m_algo = reg_wdata[1:0]; m_ord = reg_wdata[9:8];
                        m_jn = alg_n(reg_wdata[1:0]); m_acc = 0; m_words = 0; m_guard = 1;
                        if (m_target() == 0) begin m_coll = 0; m_wait = 1; m_due = cyc + DLY; end
                        else begin m_coll = 1; m_wait = 0; end
                    end
                    8'h14: m_en = reg_wdata[3:0];
                    8'h18: m_clr = reg_wdata[3:0];
                    default: ;
                endcase
            end
            m_st = (m_st & ~m_clr) | m_set;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // R10: interrupt level compared with the model at every falling edge
    always @(negedge clk) begin
        if (rst_n && cyc > 2) chk(irq === m_irq(), "R10 irq level", {31'd0, irq}, {31'd0, m_irq()});
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 60000) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1 reg_wr = 0;
    endtask

    task automatic dwr(input logic [31:0] d);
        @(negedge clk); data_wr = 1; data_wdata = d;
        @(posedge clk); #1 data_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag, output logic [31:0] got);
        logic [31:0] exp;
        @(negedge clk); reg_rd = 1; reg_addr = a;
        #1 exp = m_read(a); got = reg_rdata;
        chk(got === exp, tag, got, exp);
        @(posedge clk); #1 reg_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Open a job, feed words after the guard, wait, read back the whole queue
    task automatic run_job(input logic [1:0] alg, input logic [1:0] ord, input logic [31:0] bits,
                           input int nw, input logic [31:0] seed, input string tag);
        logic [31:0] v;
        wr(8'h08, bits);
        wr(8'h0C, {22'd0, ord, 6'd0, alg});
        idle(1);
        for (int i = 0; i < nw; i++) dwr(seed ^ (32'h1357_9BDF * (i + 1)));
        idle(DLY + 2);
        for (int i = 0; i < alg_n(alg); i++) rd(8'h1C, tag, v);
        rd(8'h10, tag, v);
        wr(8'h18, 32'hF);
    endtask

    initial begin
        logic [31:0] v;
        int first;
        idle(3);
        rst_n = 1;
        idle(1);
        // R1: reset state
        rd(8'h00, "R1 reset reg", v);
        rd(8'h04, "R1 len hi", v);
        rd(8'h08, "R1 len lo", v);
        rd(8'h0C, "R1 control", v);
        rd(8'h10, "R1 status", v);
        rd(8'h14, "R1 enable", v);
        rd(8'h50, "R1 revision", v);
        chk(v === REV, "R1 revision value", v, REV);
        chk(irq === 1'b0, "R1 irq low", {31'd0, irq}, 32'd0);

        // R2: length readback
        wr(8'h04, 32'hA5A5_0003);
        wr(8'h08, 32'h1234_5678);
        rd(8'h04, "R2 len hi", v);
        rd(8'h08, "R2 len lo", v);
        wr(8'h04, 32'h0);

        // R5: data before any job
        dwr(32'h1111_1111);
        rd(8'h10, "R5 no job", v);
        chk(v[3] === 1'b1, "R5 bit3 set", v, 32'h8);
        // R9: write-one clear
        wr(8'h18, 32'h8);
        rd(8'h10, "R9 cleared", v);
        chk(v[3:0] === 4'd0, "R9 status zero", v, 32'h0);

        // R4 and R6: guard and completion timing, SHA-256, order 0
        wr(8'h14, 32'h2);
        wr(8'h08, 32'd96);
        wr(8'h0C, 32'h0000_0003);
        dwr(32'hDEAD_BEEF);
        rd(8'h10, "R4 guard drop", v);
        chk(v[3] === 1'b1, "R4 guard bit3", v, 32'h8);
        wr(8'h18, 32'h8);
        wr(8'h0C, 32'h0000_0003);
        idle(1);
        dwr(32'h0102_0304);
        dwr(32'hA0B0_C0D0);
        dwr(32'h5555_AAAA);
        first = 0;
        for (int i = 1; i <= DLY + 2; i++) begin
            rd(8'h10, "R6 poll", v);
            if (first == 0 && v[1:0] == 2'b11) first = i;
        end
        chk(first == DLY + 1, "R6 done delay", first, DLY + 1);
        rd(8'h0C, "R2 control", v);
        for (int i = 0; i < 8; i++) rd(8'h1C, "R7 sha256 queue", v);
        rd(8'h1C, "R8 empty read", v);
        chk(v === 32'd0, "R8 empty zero", v, 32'd0);
        rd(8'h10, "R8 bit2", v);
        chk(v[2] === 1'b1, "R8 bit2 set", v, 32'h4);
        dwr(32'h7777_7777);
        rd(8'h10, "R5 after done", v);
        wr(8'h18, 32'hF);

        // R3 and R7: each lane order and algorithm
        run_job(2'd0, 2'd1, 32'd40, 2, 32'h1122_3344, "R3 order1 md5");
        run_job(2'd1, 2'd2, 32'd64, 2, 32'hCAFE_F00D, "R3 order2 sha1");
        run_job(2'd2, 2'd3, 32'd1,  1, 32'h89AB_CDEF, "R3 order3 sha224");
        run_job(2'd3, 2'd0, 32'd0,  0, 32'h0,         "R6 zero length");
        // Extra word beyond the length is refused
        wr(8'h08, 32'd32);
        wr(8'h0C, 32'h0000_0001);
        idle(1);
        dwr(32'h0F0F_0F0F);
        dwr(32'hF0F0_F0F0);
        rd(8'h10, "R5 overrun", v);
        idle(DLY);
        for (int i = 0; i < 5; i++) rd(8'h1C, "R7 sha1 queue", v);
        wr(8'h18, 32'hF);

        // R10: masking and bit 8
        wr(8'h14, 32'h4);
        rd(8'h1C, "R10 empty", v);
        rd(8'h10, "R10 bit8", v);
        chk(v[8] === 1'b1, "R10 bit8 high", v, 32'h104);
        wr(8'h14, 32'h0);
        rd(8'h10, "R10 masked", v);
        wr(8'h18, 32'hF);

        // R11: soft reset
        wr(8'h14, 32'h3);
        wr(8'h08, 32'd32);
        wr(8'h0C, 32'h0000_0002);
        idle(1);
        dwr(32'h2468_ACE0);
        wr(8'h00, 32'h1);
        wr(8'h14, 32'hF);
        dwr(32'h1357_2468);
        rd(8'h00, "R11 held", v);
        chk(v === 32'h1, "R11 reads one", v, 32'h1);
        rd(8'h14, "R11 enable ignored", v);
        wr(8'h00, 32'h0);
        idle(DLY + 2);
        rd(8'h10, "R11 status clear", v);
        rd(8'h08, "R11 length clear", v);
        rd(8'h1C, "R11 queue empty", v);

        idle(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule